// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Counters

This block predicts the next fetch address for an instruction fetch stage. It keeps a direct-mapped table of recently seen branches. Each entry carries a valid bit, the upper bits of the branch PC as a tag, the last target of that branch and a two-bit saturating direction counter. One table read therefore yields both the direction and the target. Table depth is a parameter.

Each cycle, fetch presents its PC and gets back three results at once: a hit flag, a taken/not-taken prediction and the PC to fetch next. When a branch resolves, an update carries the branch PC, its actual direction and its target. A branch that is already tracked has its counter stepped toward the outcome. A taken branch that is not yet tracked gets a new entry. A not-taken branch that is not yet tracked leaves the table as it is.

The table index is the low `log2(DEPTH)` bits of the PC and the tag is the remaining upper bits. The fall-through address is PC+1, so every PC step is one instruction.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports lk_hit=0, lk_taken=0, lk_ctr=00 and lk_next_pc=lk_pc+1.
- R2: An entry is selected by index = pc[log2(DEPTH)-1:0]. A lookup hits only when that entry is valid and its stored tag equals pc[PC_W-1:log2(DEPTH)]. A different tag at the same index is a miss.
- R3: Counter encoding: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. On a hit lk_ctr shows the stored counter, and on a miss it shows 00. lk_taken is 1 exactly when there is a hit and bit 1 of the counter is 1.
- R4: An update that hits a tracked branch increments its counter on a taken outcome, saturating at 11, and decrements it on a not-taken outcome, saturating at 00. A single opposite outcome from a strong state therefore does not flip the prediction.
- R5: lk_next_pc is the stored target when lk_taken=1, and lk_pc+1 (modulo 2^PC_W) otherwise.
- R6: An update for a taken branch that misses writes the entry at its index: valid, the new tag, the resolved target and counter 10. Any other branch that was held at that index is evicted.
- R7: An update for a not-taken branch that misses changes nothing in the table.
- R8: An update that hits with a taken outcome replaces the stored target with up_target. A not-taken outcome leaves the stored target unchanged.
- R9: When a lookup and an update address the same entry in the same cycle, the lookup reports the state held before the update. The updated state is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_pc | input | PC_W | Fetch PC to look up |
| lk_hit | output | 1 | Lookup found a valid entry with matching tag |
| lk_taken | output | 1 | Predicted taken |
| lk_ctr | output | 2 | Direction counter of the hit entry (00 on a miss) |
| lk_next_pc | output | PC_W | Predicted next fetch address |
| up_valid | input | 1 | A branch resolution is presented this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual direction of the resolved branch |
| up_target | input | PC_W | Resolved target of the branch |

## Verification
A corrupted counter shows up in the next lookup of that branch as a wrong lk_ctr. Once it crosses the taken/not-taken boundary, it also shows as a wrong lk_taken and lk_next_pc in that same lookup cycle. A bad tag or valid bit shows as a wrong lk_hit at once, either a false hit on an aliasing PC or a lost entry. A bad target stays hidden until the entry predicts taken, and then appears as a wrong lk_next_pc. The bench therefore looks up each branch right after each update and replays a long mixed-outcome run, so that each counter step is exposed within one cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // two-bit direction counter states; bit 1 is the taken prediction
  localparam logic [1:0] CTR_SNT = 2'b00;
  localparam logic [1:0] CTR_WNT = 2'b01;
  localparam logic [1:0] CTR_WT  = 2'b10;
  localparam logic [1:0] CTR_ST  = 2'b11;
endpackage

// File: rtl/btb_sat_ctr.sv
module btb_sat_ctr
  import btb_pkg::*;
(
  input  logic [1:0] cur,
  input  logic       taken,
  output logic [1:0] nxt
);
  always_comb begin
    if (taken) nxt = (cur == CTR_ST)  ? cur : cur + 2'd1;
    else       nxt = (cur == CTR_SNT) ? cur : cur - 2'd1;
  end
endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TAG_W = PC_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_load,
  input  logic             wr_tgt_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  logic [1:0]       wr_ctr,
  input  logic [IDX_W-1:0] ra_idx,
  output logic             ra_valid,
  output logic [TAG_W-1:0] ra_tag,
  output logic [PC_W-1:0]  ra_tgt,
  output logic [1:0]       ra_ctr,
  input  logic [IDX_W-1:0] rb_idx,
  output logic             rb_valid,
  output logic [TAG_W-1:0] rb_tag,
  output logic [1:0]       rb_ctr
);
  logic [DEPTH-1:0] valid_q, valid_d, sel;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];
  logic [1:0]       ctr_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_sel
    assign sel[e] = wr_en && (wr_idx == IDX_W'(e));
  end

  always_comb begin
    valid_d = valid_q;
    if (wr_en && wr_load) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (sel[e])              ctr_q[e] <= wr_ctr;
      if (sel[e] && wr_load)   tag_q[e] <= wr_tag;
      if (sel[e] && wr_tgt_en) tgt_q[e] <= wr_tgt;
    end
  end

  assign ra_valid = valid_q[ra_idx];
  assign ra_tag   = tag_q[ra_idx];
  assign ra_tgt   = tgt_q[ra_idx];
  assign ra_ctr   = ctr_q[ra_idx];
  assign rb_valid = valid_q[rb_idx];
  assign rb_tag   = tag_q[rb_idx];
  assign rb_ctr   = ctr_q[rb_idx];

  // R4: a counter refresh moves the stored state by at most one step
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_load && rb_idx == wr_idx && rb_valid)
      |=> ((ctr_q[$past(wr_idx)] - $past(rb_ctr)) != 2'd2));

  // R6: an allocation leaves a valid entry in weak-taken state
  a_r6_alloc_weak_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_load)
      |=> (valid_q[$past(wr_idx)] && ctr_q[$past(wr_idx)] == CTR_WT));

  // R7: without a write, occupancy is unchanged
  a_r7_hold_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(valid_q));
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [1:0]      lk_ctr,
  output logic [PC_W-1:0] lk_next_pc,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TAG_W = PC_W - IDX_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic             ra_valid, rb_valid;
  logic [TAG_W-1:0] ra_tag, rb_tag;
  logic [PC_W-1:0]  ra_tgt;
  logic [1:0]       ra_ctr, rb_ctr, sat_nxt;
  logic             up_hit, wr_en, wr_load, wr_tgt_en;
  logic [1:0]       wr_ctr;

  btb_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_i),
    .wr_en    (wr_en),
    .wr_idx   (up_pc[IDX_W-1:0]),
    .wr_load  (wr_load),
    .wr_tgt_en(wr_tgt_en),
    .wr_tag   (up_pc[PC_W-1:IDX_W]),
    .wr_tgt   (up_target),
    .wr_ctr   (wr_ctr),
    .ra_idx   (lk_pc[IDX_W-1:0]),
    .ra_valid (ra_valid),
    .ra_tag   (ra_tag),
    .ra_tgt   (ra_tgt),
    .ra_ctr   (ra_ctr),
    .rb_idx   (up_pc[IDX_W-1:0]),
    .rb_valid (rb_valid),
    .rb_tag   (rb_tag),
    .rb_ctr   (rb_ctr)
  );

  btb_sat_ctr u_sat (.cur(rb_ctr), .taken(up_taken), .nxt(sat_nxt));

  // lookup path
  always_comb begin
    lk_hit     = ra_valid && (ra_tag == lk_pc[PC_W-1:IDX_W]);
    lk_ctr     = lk_hit ? ra_ctr : CTR_SNT;
    lk_taken   = lk_hit && ra_ctr[1];
    lk_next_pc = lk_taken ? ra_tgt : lk_pc + PC_W'(1);
  end

  // update path
  always_comb begin
    up_hit    = rb_valid && (rb_tag == up_pc[PC_W-1:IDX_W]);
    wr_en     = up_valid && (up_hit || up_taken);
    wr_load   = !up_hit;
    wr_tgt_en = up_taken;
    wr_ctr    = up_hit ? sat_nxt : CTR_WT;
  end

  always_comb begin
    if (rst_i) begin
      a_r5_fall_through: assert (lk_taken || lk_next_pc == lk_pc + PC_W'(1));
      a_r3_taken_needs_hit: assert (!lk_taken || lk_hit);
      a_r4_sat_top: assert (!(up_valid && up_hit && up_taken && rb_ctr == CTR_ST)
                            || wr_ctr == CTR_ST);
      a_r4_sat_bottom: assert (!(up_valid && up_hit && !up_taken && rb_ctr == CTR_SNT)
                               || wr_ctr == CTR_SNT);
    end
  end
endmodule

// File: tb/test_btb_predictor.sv
`timescale 1ns/1ps
module test_btb_predictor;
  localparam int PC_W  = 16;
  localparam int DEPTH = 8;

  logic            clk, rst_n;
  logic [PC_W-1:0] lk_pc, lk_next_pc, up_pc, up_target;
  logic            lk_hit, lk_taken, up_valid, up_taken;
  logic [1:0]      lk_ctr;
  int errors = 0;
  int checks = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .DEPTH(DEPTH)) i_btb_predictor (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .lk_ctr(lk_ctr), .lk_next_pc(lk_next_pc), .up_valid(up_valid), .up_pc(up_pc),
    .up_taken(up_taken), .up_target(up_target));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
    if (t) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  // compare the current outputs against an expected entry state
  task automatic cmp(input string tag, input logic [PC_W-1:0] pc, input logic hit,
                     input logic [1:0] ctr, input logic [PC_W-1:0] tgt);
    logic tk;
    logic [PC_W-1:0] nx;
    tk = hit & ctr[1];
    nx = tk ? tgt : pc + 1'b1;
    chk({tag, " hit"}, 32'(lk_hit), 32'(hit));
    chk({tag, " ctr"}, 32'(lk_ctr), 32'(hit ? ctr : 2'd0));
    chk({tag, " taken"}, 32'(lk_taken), 32'(tk));
    chk({tag, " next"}, 32'(lk_next_pc), 32'(nx));
  endtask

  task automatic look(input string tag, input logic [PC_W-1:0] pc, input logic hit,
                      input logic [1:0] ctr, input logic [PC_W-1:0] tgt);
    @(negedge clk);
    lk_pc = pc;
    #1;
    cmp(tag, pc, hit, ctr, tgt);
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input logic tk, input logic [PC_W-1:0] tgt);
    @(negedge clk);
    up_pc = pc; up_taken = tk; up_target = tgt; up_valid = 1'b1;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1:0] ref_c;
    logic [14:0] seq;
    rst_n = 1'b0; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0; up_target = '0;
    lk_pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: all entries empty after reset
    for (int i = 0; i < DEPTH; i++) look("R1 reset", 16'h0100 + 16'(i), 1'b0, 2'd0, 16'h0);
    // R5: fall-through wraps
    look("R5 wrap", 16'hFFFF, 1'b0, 2'd0, 16'h0);

    // R7: not-taken miss allocates nothing
    upd(16'h0103, 1'b0, 16'h0444);
    look("R7 no alloc", 16'h0103, 1'b0, 2'd0, 16'h0);

    // R6: taken miss allocates weak-taken with target
    upd(16'h0103, 1'b1, 16'h0040);
    look("R6 alloc", 16'h0103, 1'b1, 2'd2, 16'h0040);
    // R2: same index, different tag misses
    look("R2 alias miss", 16'h0203, 1'b0, 2'd0, 16'h0);

    // R8 / R4: taken refreshes target, not-taken keeps it; strong survives one miss
    upd(16'h0103, 1'b1, 16'h0050);
    look("R8 retarget", 16'h0103, 1'b1, 2'd3, 16'h0050);
    upd(16'h0103, 1'b0, 16'h0777);
    look("R8 keep target R4 no flip", 16'h0103, 1'b1, 2'd2, 16'h0050);

    // R6: eviction of the other occupant
    upd(16'h0203, 1'b1, 16'h0099);
    look("R6 replace", 16'h0203, 1'b1, 2'd2, 16'h0099);
    look("R6 evicted", 16'h0103, 1'b0, 2'd0, 16'h0);

    // R9: same-cycle lookup sees old state
    @(negedge clk);
    up_pc = 16'h0203; up_taken = 1'b0; up_target = 16'h0; up_valid = 1'b1;
    lk_pc = 16'h0203;
    #1;
    cmp("R9 old state", 16'h0203, 1'b1, 2'd2, 16'h0099);
    @(negedge clk);
    up_valid = 1'b0;
    #1;
    cmp("R9 new state", 16'h0203, 1'b1, 2'd1, 16'h0099);

    // R2/R6 sweep: fill every index, then read all back
    for (int i = 0; i < DEPTH; i++) upd(16'h0A00 + 16'(i), 1'b1, 16'h1000 + 16'(i * 7));
    for (int i = 0; i < DEPTH; i++)
      look("R2 sweep", 16'h0A00 + 16'(i), 1'b1, 2'd2, 16'h1000 + 16'(i * 7));

    // R4: bottom saturation and slow recovery
    ref_c = 2'd2;
    for (int k = 0; k < 4; k++) begin
      upd(16'h0A05, 1'b0, 16'h0);
      ref_c = sat(ref_c, 1'b0);
      look("R4 down", 16'h0A05, 1'b1, ref_c, 16'h1000 + 16'(5 * 7));
    end
    upd(16'h0A05, 1'b1, 16'h1023);
    look("R4 one up stays NT", 16'h0A05, 1'b1, 2'd1, 16'h1023);
    // R4: top saturation
    ref_c = 2'd2;
    for (int k = 0; k < 3; k++) begin
      upd(16'h0A06, 1'b1, 16'h1000 + 16'(6 * 7));
      ref_c = sat(ref_c, 1'b1);
      look("R4 up", 16'h0A06, 1'b1, ref_c, 16'h1000 + 16'(6 * 7));
    end

    // R3/R4/R5: replay of TTTTNTTNNNTNTNN from weak taken
    upd(16'h0C04, 1'b1, 16'h0321);
    seq = 15'b111101100010100;
    ref_c = 2'd2;
    for (int k = 0; k < 15; k++) begin
      look("R3 replay", 16'h0C04, 1'b1, ref_c, 16'h0321);
      upd(16'h0C04, seq[14 - k], 16'h0321);
      ref_c = sat(ref_c, seq[14 - k]);
    end
    look("R4 replay end", 16'h0C04, 1'b1, ref_c, 16'h0321);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule